// File: doc/BRIEF.md
# Banked Register File with Pointer Indirection

This block is the data-memory front end of an 8-bit controller core. The CPU gives it a 7-bit offset taken from the instruction word. The block adds a bank bit, read from its own flags register, to form an 8-bit data address, so two banks of 128 bytes can be reached. The block stores the flags register, an 8-bit address pointer and the general-purpose RAM. Every other special-function offset goes out on a peripheral port, so the registers held outside the block can answer it.

Offset 0 has no storage behind it. Any access to offset 0 uses the pointer contents as the full data address and ignores the bank bit. A small set of special offsets is the same in both banks. The block folds the bank-1 copy of each of these onto its bank-0 address, so both banks reach one physical register. Reads are combinational and writes take effect at the clock edge.

Top module: `breg_file`

## Requirements
- R1: A direct access (offset not 0) targets address {RP, offset}. RP is bit 5 of the flags register, so RP=0 selects addresses 0x00–0x7F and RP=1 selects 0x80–0xFF.
- R2: The flags register (offset 0x03) has carry in bit 0, digit carry in bit 1, zero in bit 2 and RP in bit 5. Writes load these four bits. Bits 7:6 always read as zero.
- R3: After reset the flags register reads 0x18, with bits 4 and 3 set. The pointer and all general-purpose bytes read 0x00.
- R4: Writes to the flags register never change bits 4 (time-out, active low) and 3 (power-down, active low).
- R5: Offsets 0x02, 0x03, 0x04 and 0x0A reach the same register from either bank. A write made through bank 1 reads back through bank 0, and the reverse also holds.
- R6: The pointer register (offset 0x04) can be read and written. An access at offset 0 uses all 8 pointer bits as the address, whatever the value of RP.
- R7: An indirect access whose pointer has bits 6:0 equal to zero (pointer 0x00 or 0x80) reads 0x00. A write through such a pointer changes no register and raises no peripheral write.
- R8: Addresses 0x20–0x7F and 0xA0–0xFF are separate general-purpose bytes. Each one keeps the last value written to it.
- R9: Addresses with bits 6:0 in 0x01–0x1F, other than the flags and pointer offsets, go to the peripheral port. The address on the port is the folded address, with R5 applied. A write raises the peripheral write enable for that cycle only. A read returns the peripheral read data.
- R10: A read returns the value held before any write in the same cycle. A write to the flags register changes the bank used from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_off | input | 7 | Read offset from the instruction |
| rd_data | output | 8 | Read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_off | input | 7 | Write offset from the instruction |
| wr_data | input | 8 | Write data |
| per_rd_addr | output | 8 | Folded read address sent to the peripherals |
| per_rd_data | input | 8 | Peripheral read data |
| per_wr_en | output | 1 | Peripheral write enable |
| per_wr_addr | output | 8 | Folded write address sent to the peripherals |
| per_wr_data | output | 8 | Peripheral write data |

## Verification
The assertions assume that the peripheral side answers combinationally within the cycle. They also assume that offsets and write strobes are stable between clock edges, so one write never overlaps another. The stimulus changes inputs only on the falling edge. It mixes random offsets, pointer values and flags writes, which flip the bank often. About a quarter of the accesses are steered to offset 0, so the indirect path and the null pointer values get frequent use. The peripheral responder returns a fixed function of the address it is given, which makes any wrong folding show up in the read data.

// File: rtl/breg_file.sv
module breg_file #(
  parameter int GPR_BASE = 32,
  parameter int RP_BIT   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] rd_off,
  output logic [7:0] rd_data,
  input  logic       wr_en,
  input  logic [6:0] wr_off,
  input  logic [7:0] wr_data,
  output logic [7:0] per_rd_addr,
  input  logic [7:0] per_rd_data,
  output logic       per_wr_en,
  output logic [7:0] per_wr_addr,
  output logic [7:0] per_wr_data
);
  localparam int GPR_PER_BANK = 128 - GPR_BASE;
  localparam int GPR_WORDS    = 2 * GPR_PER_BANK;
  localparam int GIW          = $clog2(GPR_WORDS);
  localparam logic [6:0] O_IND = 7'h00, O_PCL = 7'h02, O_STAT = 7'h03,
                         O_PTR = 7'h04, O_PCH = 7'h0A;
  localparam logic [7:0] STAT_RST   = 8'h18;
  localparam logic [7:0] STAT_WMASK = 8'h07 | (8'h01 << RP_BIT);

  typedef enum logic [2:0] {K_NULL, K_STAT, K_PTR, K_PER, K_GPR} kind_t;

  logic [7:0] stat_q, ptr_q;
  logic [7:0] gpr_q [GPR_WORDS];

  function automatic logic is_mirror(input logic [6:0] lo);
    return lo == O_PCL || lo == O_STAT || lo == O_PTR || lo == O_PCH;
  endfunction

  function automatic logic [7:0] fold(input logic [6:0] off, input logic [7:0] ptr,
                                      input logic rp);
    logic [7:0] a;
    a = (off == O_IND) ? ptr : {rp, off};
    return is_mirror(a[6:0]) ? {1'b0, a[6:0]} : a;
  endfunction

  function automatic kind_t classify(input logic [7:0] a);
    if (a[6:0] == O_IND)               return K_NULL;
    if (a == {1'b0, O_STAT})           return K_STAT;
    if (a == {1'b0, O_PTR})            return K_PTR;
    if (int'(a[6:0]) >= GPR_BASE)      return K_GPR;
    return K_PER;
  endfunction

  function automatic logic [GIW-1:0] gidx(input logic [7:0] a);
    return GIW'((a[7] ? GPR_PER_BANK : 0) + int'(a[6:0]) - GPR_BASE);
  endfunction

  logic [7:0] rd_addr, wr_addr;
  kind_t      rd_kind, wr_kind;

  assign rd_addr = fold(rd_off, ptr_q, stat_q[RP_BIT]);
  assign wr_addr = fold(wr_off, ptr_q, stat_q[RP_BIT]);
  assign rd_kind = classify(rd_addr);
  assign wr_kind = classify(wr_addr);

  assign per_rd_addr = rd_addr;
  assign per_wr_addr = wr_addr;
  assign per_wr_data = wr_data;
  assign per_wr_en   = wr_en && wr_kind == K_PER;

  always_comb begin
    case (rd_kind)
      K_STAT:  rd_data = stat_q;
      K_PTR:   rd_data = ptr_q;
      K_PER:   rd_data = per_rd_data;
      K_GPR:   rd_data = gpr_q[gidx(rd_addr)];
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      ptr_q  <= 8'h00;
      for (int i = 0; i < GPR_WORDS; i++) gpr_q[i] <= 8'h00;
    end else if (wr_en) begin
      case (wr_kind)
        K_STAT:  stat_q <= (stat_q & ~STAT_WMASK) | (wr_data & STAT_WMASK);
        K_PTR:   ptr_q  <= wr_data;
        K_GPR:   gpr_q[gidx(wr_addr)] <= wr_data;
        default: ;
      endcase
    end
  end

  AST_PDTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stat_q[4:3] == $past(stat_q[4:3])); // R4
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_kind == K_STAT |=> stat_q[2:0] == $past(wr_data[2:0])); // R2
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_kind == K_PTR |=> ptr_q == $past(wr_data)); // R6
  AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_off == O_IND && ptr_q[6:0] == 7'h00 |-> rd_data == 8'h00); // R7
  AST_PER_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_en |-> !(per_wr_addr[7] && is_mirror(per_wr_addr[6:0]))); // R5
  AST_PER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr_en |-> int'(per_wr_addr[6:0]) < GPR_BASE && per_wr_addr[6:0] != 7'h00); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_kind == K_STAT) |=> $stable(stat_q)); // R10
endmodule

// File: tb/breg_file_test.sv
module breg_file_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] rd_off = '0, wr_off = '0;
  logic [7:0] wr_data = '0, rd_data, per_rd_addr, per_rd_data, per_wr_addr, per_wr_data;
  logic wr_en = 1'b0, per_wr_en;
  int checks = 0, errors = 0;

  logic [7:0] m_stat = 8'h18, m_ptr = 8'h00;
  logic [7:0] m_gpr [256];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign per_rd_data = per_rd_addr ^ 8'h5A;

  breg_file uut (.clk(clk), .rst_n(rst_n), .rd_off(rd_off), .rd_data(rd_data),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data), .per_rd_addr(per_rd_addr),
    .per_rd_data(per_rd_data), .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr),
    .per_wr_data(per_wr_data));

  function automatic logic [7:0] b_addr(input logic [6:0] off);
    logic [7:0] a;
    a = (off == 7'h00) ? m_ptr : {m_stat[5], off};
    if (a[6:0] == 7'h02 || a[6:0] == 7'h03 || a[6:0] == 7'h04 || a[6:0] == 7'h0A) a[7] = 1'b0;
    return a;
  endfunction

  function automatic int b_kind(input logic [7:0] a);
    if (a[6:0] == 7'h00) return 0;
    if (a == 8'h03) return 1;
    if (a == 8'h04) return 2;
    if (a[6:0] >= 7'h20) return 4;
    return 3;
  endfunction

  function automatic logic [7:0] b_read(input logic [6:0] off);
    logic [7:0] a;
    a = b_addr(off);
    case (b_kind(a))
      1: return m_stat;
      2: return m_ptr;
      3: return a ^ 8'h5A;
      4: return m_gpr[a];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string b_tag(input logic [6:0] off);
    case (b_kind(b_addr(off)))
      0: return "R7";
      1: return "R2";
      2: return "R6";
      3: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [6:0] woff, input logic [7:0] wd,
                      input logic [6:0] roff, input string tag);
    logic [7:0] wa;
    int wk;
    @(negedge clk);
    wr_en = we; wr_off = woff; wr_data = wd; rd_off = roff;
    #1;
    chk(tag == "" ? b_tag(roff) : tag, rd_data, b_read(roff));
    wa = b_addr(woff);
    wk = b_kind(wa);
    chk("R9", {7'h00, per_wr_en}, {7'h00, we && wk == 3});
    if (we && wk == 3) chk("R9", per_wr_addr, wa);
    @(posedge clk);
    #1;
    if (we) begin
      case (wk)
        1: m_stat = {2'b00, wd[5], m_stat[4:3], wd[2:0]};
        2: m_ptr = wd;
        4: m_gpr[wa] = wd;
        default: ;
      endcase
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_gpr[i] = 8'h00;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 7'h03, "R3");
    step(0, 0, 0, 7'h04, "R3");
    step(0, 0, 0, 7'h45, "R3");
    step(1, 7'h03, 8'hFF, 7'h00, "R7");
    step(0, 0, 0, 7'h03, "R4");
    step(1, 7'h30, 8'h11, 7'h03, "R2");
    step(1, 7'h03, 8'h00, 7'h30, "R1");
    step(1, 7'h30, 8'h22, 7'h30, "R10");
    step(0, 0, 0, 7'h30, "R1");
    step(1, 7'h03, 8'h20, 7'h30, "R10");
    step(0, 0, 0, 7'h30, "R1");
    step(1, 7'h04, 8'hB0, 7'h0A, "R9");
    step(1, 7'h03, 8'h00, 7'h04, "R5");
    step(0, 0, 0, 7'h00, "R6");
    step(1, 7'h04, 8'h80, 7'h00, "R6");
    step(1, 7'h00, 8'h77, 7'h00, "R7");
    step(0, 0, 0, 7'h30, "R7");
    step(1, 7'h0A, 8'h33, 7'h02, "R5");
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] ro, wo;
      logic we;
      ro = 7'($urandom);
      wo = 7'($urandom);
      if ($urandom % 4 == 0) ro = 7'h00;
      if ($urandom % 4 == 0) wo = 7'h00;
      if ($urandom % 8 == 0) wo = 7'h04;
      if ($urandom % 10 == 0) wo = 7'h03;
      we = ($urandom % 3) != 0;
      step(we, wo, 8'($urandom), ro, "");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule